// File: doc/BRIEF.md
# Packed Mixed-Sign Dot-Product Accumulator

This block is a vector multiply-accumulate datapath for packed 16-bit words. Each 32-bit output lane takes two neighbouring word pairs from the A and B operand buses, multiplies each pair, and adds both products to the matching 32-bit accumulator lane. A two-bit operand-kind input chooses which operand is treated as signed. A saturation-enable input selects modular (wrap-around) accumulation or clamping. For the two mixed-sign kinds the clamp is signed. For the all-unsigned kind the clamp is unsigned.

The buses are always sized for the widest configuration, which has eight lanes. The `LANES` parameter sets 4 or 8 active lanes. Output lanes above the active count read zero, and input bits in those lanes are ignored. Each accepted input is registered once. A two-state output controller tracks whether the register holds a fresh result. In `ST_EMPTY` no fresh result is present and `out_valid` is low. In `ST_READY` the register holds the result of the previous cycle's input and `out_valid` is high.

The controller has two transitions, ACCEPT and DRAIN, plus a reset return:
- ACCEPT: in_valid high, from either state into `ST_READY`.
- DRAIN: in_valid low, from either state into `ST_EMPTY`.
- Reset: a synchronous reset returns the controller to `ST_EMPTY`.

Top module: `dotacc_vec`

## Requirements
- R1: Output lane j (bits [32j+31:32j]) is computed from accumulator lane j (`acc_in` bits [32j+31:32j]) and from words 2j and 2j+1 of `a_in` and `b_in`. Word k occupies bits [16k+15:16k]. Word 2j of A is multiplied by word 2j of B, and word 2j+1 of A by word 2j+1 of B.
- R2: The `kind` encoding is as follows:
  - 0: A is signed and B is unsigned.
  - 1: A is unsigned and B is signed.
  - 2: both operands are unsigned.
  - 3: behaves exactly like 2.
  - A signed word is sign-extended and an unsigned word is zero-extended.
- R3: With `sat_en`=0 the lane result is the low 32 bits of the exact sum of the accumulator lane and both products. The result therefore wraps modulo 2^32.
- R4: With `sat_en`=1 and kind 0 or 1, the accumulator lane is read as signed two's complement. The exact sum is clamped to the range 0x80000000 to 0x7FFFFFFF.
- R5: With `sat_en`=1 and kind 2 or 3, the accumulator lane is read as unsigned. The exact sum is clamped to at most 0xFFFFFFFF.
- R6: With LANES=4, `out_data` bits [255:128] are always zero, and input bits above bit 127 of every bus have no effect on the output. With LANES=8, all eight lanes are computed.
- R7: `out_valid` in the cycle after a clock edge equals the `in_valid` sampled at that edge. When `in_valid` is high, `out_data` loads that cycle's result at the same edge.
- R8: A clock edge with `in_valid` low leaves `out_data` unchanged.
- R9: A synchronous active-high `rst` clears `out_data` to zero and `out_valid` to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| kind | input | 2 | Operand signedness selection (R2) |
| sat_en | input | 1 | 1 = clamp, 0 = wrap |
| acc_in | input | 256 | Eight 32-bit accumulator lanes |
| a_in | input | 256 | Sixteen 16-bit A words |
| b_in | input | 256 | Sixteen 16-bit B words |
| out_valid | output | 1 | Registered result is fresh |
| out_data | output | 256 | Eight 32-bit result lanes |

## Verification
The bench targets the following corner cases:

- **0x8000 × 0xFFFF and 0xFFFF × 0xFFFF pairs.** If the signed operand were zero-extended, or the unsigned one sign-extended, these products would have the wrong sign or the wrong magnitude.
- **Accumulators at 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF.** A design that read the accumulator with the wrong signedness for the kind, or that took the saturation decision on a 33-bit sum, would clamp to the wrong rail or would not clamp at all. For example, 0x80000000 plus 0xFFFF×0xFFFF must saturate to all ones in the unsigned kind, but a design that reads the accumulator as signed would give 0x7FFE0001.
- **Kind 3.** A design that decodes kind 3 as a signed kind would produce a signed result where the unsigned one is required.
- **Upper lanes and word ordering.** Distinct per-lane data exposes swapped words and a non-zero upper half in the four-lane build.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;

    typedef enum logic [1:0] {
        KIND_SGN_UNS = 2'd0,
        KIND_UNS_SGN = 2'd1,
        KIND_UNS_UNS = 2'd2,
        KIND_UNS_ALT = 2'd3
    } kind_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_READY = 1'b1
    } ostate_t;

    function automatic logic kind_a_signed(kind_t k);
        return k == KIND_SGN_UNS;
    endfunction

    function automatic logic kind_b_signed(kind_t k);
        return k == KIND_UNS_SGN;
    endfunction

    // Mixed-sign kinds treat the accumulator as signed; unsigned kinds do not.
    function automatic logic kind_acc_signed(kind_t k);
        return !k[1];
    endfunction

endpackage

// File: rtl/dotacc_ext.sv
module dotacc_ext #(
    parameter int WORD_W = 16
) (
    input  logic                     is_signed,
    input  logic [WORD_W-1:0]        word,
    output logic signed [WORD_W:0]   wide
);
    always_comb begin
        wide = {is_signed & word[WORD_W-1], word};
    end
endmodule

// File: rtl/dotacc_clamp.sv
module dotacc_clamp #(
    parameter int SUM_W = 36,
    parameter int ACC_W = 32
) (
    input  logic signed [SUM_W-1:0] sum,
    input  logic                    sat_en,
    input  logic                    uns_rail,
    output logic [ACC_W-1:0]        res
);
    localparam logic signed [SUM_W-1:0] SMAX = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SMIN = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] UMAX = {{(SUM_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};
    localparam logic signed [SUM_W-1:0] ZERO = '0;

    always_comb begin
        res = sum[ACC_W-1:0];
        if (sat_en) begin
            if (uns_rail) begin
                if (sum > UMAX)      res = {ACC_W{1'b1}};
                else if (sum < ZERO) res = '0;
            end else begin
                if (sum > SMAX)      res = {1'b0, {(ACC_W-1){1'b1}}};
                else if (sum < SMIN) res = {1'b1, {(ACC_W-1){1'b0}}};
            end
        end
    end
endmodule

// File: rtl/dotacc_lane.sv
module dotacc_lane
    import dotacc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ACC_W  = 32
) (
    input  kind_t              kind,
    input  logic               sat_en,
    input  logic [ACC_W-1:0]   acc,
    input  logic [2*WORD_W-1:0] a_pair,
    input  logic [2*WORD_W-1:0] b_pair,
    output logic [ACC_W-1:0]   res
);
    localparam int EXT_W  = WORD_W + 1;
    localparam int PROD_W = 2 * EXT_W;
    localparam int SUM_W  = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 2;

    logic                    a_sgn, b_sgn, acc_sgn;
    logic signed [EXT_W-1:0] ax [2];
    logic signed [EXT_W-1:0] bx [2];
    logic signed [PROD_W-1:0] prod [2];
    logic signed [SUM_W-1:0] acc_x, p0_x, p1_x, sum;

    always_comb begin
        a_sgn   = kind_a_signed(kind);
        b_sgn   = kind_b_signed(kind);
        acc_sgn = kind_acc_signed(kind);
    end

    for (genvar w = 0; w < 2; w++) begin : g_word
        dotacc_ext #(.WORD_W(WORD_W)) u_ext_a (
            .is_signed (a_sgn),
            .word      (a_pair[w*WORD_W +: WORD_W]),
            .wide      (ax[w])
        );
        dotacc_ext #(.WORD_W(WORD_W)) u_ext_b (
            .is_signed (b_sgn),
            .word      (b_pair[w*WORD_W +: WORD_W]),
            .wide      (bx[w])
        );
        always_comb prod[w] = ax[w] * bx[w];
    end

    always_comb begin
        acc_x = {{(SUM_W-ACC_W){acc_sgn & acc[ACC_W-1]}}, acc};
        p0_x  = {{(SUM_W-PROD_W){prod[0][PROD_W-1]}}, prod[0]};
        p1_x  = {{(SUM_W-PROD_W){prod[1][PROD_W-1]}}, prod[1]};
        sum   = acc_x + p0_x + p1_x;
    end

    dotacc_clamp #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_clamp (
        .sum      (sum),
        .sat_en   (sat_en),
        .uns_rail (!acc_sgn),
        .res      (res)
    );
endmodule

// File: rtl/dotacc_vec.sv
module dotacc_vec
    import dotacc_pkg::*;
#(
    parameter int MAX_LANES = 8,
    parameter int LANES     = 4,
    parameter int WORD_W    = 16,
    parameter int ACC_W     = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [1:0]                      kind,
    input  logic                            sat_en,
    input  logic [MAX_LANES*ACC_W-1:0]      acc_in,
    input  logic [MAX_LANES*2*WORD_W-1:0]   a_in,
    input  logic [MAX_LANES*2*WORD_W-1:0]   b_in,
    output logic                            out_valid,
    output logic [MAX_LANES*ACC_W-1:0]      out_data
);
    localparam int BUS_W  = MAX_LANES * ACC_W;
    localparam int ACT_W  = LANES * ACC_W;
    localparam int PAIR_W = 2 * WORD_W;

    if (!(LANES == 4 || LANES == 8) || LANES > MAX_LANES) begin : g_bad_lanes
        $error("dotacc_vec: LANES must be 4 or 8 and not exceed MAX_LANES");
    end

    kind_t              kind_q;
    logic [BUS_W-1:0]   lane_bus;
    ostate_t            state, state_nx;

    always_comb kind_q = kind_t'(kind);

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        if (g < LANES) begin : g_on
            dotacc_lane #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_lane (
                .kind   (kind_q),
                .sat_en (sat_en),
                .acc    (acc_in[g*ACC_W +: ACC_W]),
                .a_pair (a_in[g*PAIR_W +: PAIR_W]),
                .b_pair (b_in[g*PAIR_W +: PAIR_W]),
                .res    (lane_bus[g*ACC_W +: ACC_W])
            );
        end else begin : g_off
            logic unused_lane_bits;
            assign unused_lane_bits = ^{acc_in[g*ACC_W +: ACC_W],
                                        a_in[g*PAIR_W +: PAIR_W],
                                        b_in[g*PAIR_W +: PAIR_W]};
            assign lane_bus[g*ACC_W +: ACC_W] = '0;
        end
    end

    // Output controller: next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: state_nx = in_valid ? ST_READY : ST_EMPTY;
            ST_READY: state_nx = in_valid ? ST_READY : ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    // Result register
    always_ff @(posedge clk) begin
        if (rst)           out_data <= '0;
        else if (in_valid) out_data <= lane_bus;
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_READY: out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    if (LANES < MAX_LANES) begin : g_chk_upper
        assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
            out_data[BUS_W-1:ACT_W] == '0);
    end
endmodule

// File: tb/dotacc_vec_test.sv
`timescale 1ns/1ps
module dotacc_vec_test;
    localparam int ML = 8;

    typedef struct packed {
        logic [1:0]  md;
        logic        sat;
        logic [31:0] acc;
        logic [15:0] a0, a1, b0, b1;
        logic [31:0] exp;
    } vec_t;

    // kind, sat, acc, a0, a1, b0, b1, expected lane result
    localparam vec_t TBL [15] = '{
        '{2'd0, 1'b0, 32'd10,         16'h0002, 16'hFFFF, 16'd3,    16'd5,    32'h0000000B}, // R2 R3
        '{2'd0, 1'b0, 32'd0,          16'h8000, 16'h8000, 16'hFFFF, 16'hFFFF, 32'h00010000}, // R3 wrap
        '{2'd0, 1'b1, 32'd0,          16'h8000, 16'h8000, 16'hFFFF, 16'hFFFF, 32'h80000000}, // R4 low rail
        '{2'd1, 1'b0, 32'd0,          16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 32'hFFFF0001}, // R2 kind1
        '{2'd2, 1'b0, 32'hFFFFFFFF,   16'h0001, 16'h0000, 16'h0001, 16'h0000, 32'h00000000}, // R3 uu wrap
        '{2'd2, 1'b1, 32'hFFFFFFFF,   16'h0001, 16'h0000, 16'h0001, 16'h0000, 32'hFFFFFFFF}, // R5
        '{2'd2, 1'b1, 32'd0,          16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'hFFFFFFFF}, // R5
        '{2'd2, 1'b0, 32'd0,          16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'hFFFC0002}, // R3
        '{2'd0, 1'b1, 32'h7FFFFFFF,   16'h0001, 16'h0000, 16'h0001, 16'h0000, 32'h7FFFFFFF}, // R4 high rail
        '{2'd1, 1'b1, 32'h80000000,   16'h0001, 16'h0000, 16'hFFFF, 16'h0000, 32'h80000000}, // R4
        '{2'd0, 1'b1, 32'hFFFFFFFE,   16'h0003, 16'hFFFE, 16'h0004, 16'h0002, 32'h00000006}, // R4 in range
        '{2'd2, 1'b1, 32'h80000000,   16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 32'hFFFFFFFF}, // R5 unsigned acc
        '{2'd3, 1'b1, 32'hFFFFFFF0,   16'hFFFF, 16'h0000, 16'h0002, 16'h0000, 32'hFFFFFFFF}, // R2 kind3
        '{2'd0, 1'b0, 32'd100,        16'h0001, 16'h0002, 16'h0010, 16'h0100, 32'h00000274}, // R1 order
        '{2'd1, 1'b1, 32'h7FFF0000,   16'h0001, 16'h0000, 16'h7FFF, 16'h0000, 32'h7FFF7FFF}  // R4 in range
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   kind = 2'd0;
    logic         sat_en = 1'b0;
    logic [255:0] acc_in = '0, a_in = '0, b_in = '0;
    logic         out_valid, out_valid_w;
    logic [255:0] out_data, out_data_w;
    int           n_chk = 0, n_fail = 0;
    bit           done = 0;

    always #2 clk = ~clk;

    dotacc_vec #(.LANES(4)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .sat_en(sat_en),
        .acc_in(acc_in), .a_in(a_in), .b_in(b_in),
        .out_valid(out_valid), .out_data(out_data));

    dotacc_vec #(.LANES(8)) uut_w (
        .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .sat_en(sat_en),
        .acc_in(acc_in), .a_in(a_in), .b_in(b_in),
        .out_valid(out_valid_w), .out_data(out_data_w));

    function automatic logic [31:0] ref_lane(logic [1:0] md, logic sat, logic [31:0] acc,
                                             logic [15:0] a0, logic [15:0] a1,
                                             logic [15:0] b0, logic [15:0] b1);
        longint av0, av1, bv0, bv1, accv, s;
        bit uu = md[1];
        av0 = (md == 2'd0) ? longint'($signed(a0)) : longint'(a0);
        av1 = (md == 2'd0) ? longint'($signed(a1)) : longint'(a1);
        bv0 = (md == 2'd1) ? longint'($signed(b0)) : longint'(b0);
        bv1 = (md == 2'd1) ? longint'($signed(b1)) : longint'(b1);
        accv = uu ? longint'(acc) : longint'($signed(acc));
        s = accv + av0 * bv0 + av1 * bv1;
        if (!sat) return s[31:0];
        if (uu) return (s > 64'sd4294967295) ? 32'hFFFFFFFF : s[31:0];
        if (s > 64'sd2147483647) return 32'h7FFFFFFF;
        if (s < -64'sd2147483648) return 32'h80000000;
        return s[31:0];
    endfunction

    function automatic logic [255:0] ref_vec(logic [1:0] md, logic sat, logic [255:0] acc,
                                             logic [255:0] a, logic [255:0] b, int lanes);
        logic [255:0] r = '0;
        for (int l = 0; l < lanes; l++)
            r[l*32 +: 32] = ref_lane(md, sat, acc[l*32 +: 32],
                                     a[l*32 +: 16], a[l*32+16 +: 16],
                                     b[l*32 +: 16], b[l*32+16 +: 16]);
        return r;
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Called at a negedge; returns at the negedge after the capturing edge.
    task automatic apply(logic [1:0] md, logic sat, logic [255:0] acc,
                         logic [255:0] a, logic [255:0] b);
        kind = md; sat_en = sat; acc_in = acc; a_in = a; b_in = b; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [255:0] acc, a, b, expw, expn, held;
        logic [15:0]  cw [4];
        logic [31:0]  ca [4];
        cw = '{16'h8000, 16'hFFFF, 16'h7FFF, 16'h0001};
        ca = '{32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h00000000};

        repeat (3) @(negedge clk);
        check("R9 reset valid", {255'b0, out_valid}, 256'd0);
        check("R9 reset data", out_data, 256'd0);
        rst = 1'b0;

        // Table walk: table vector in lane i%4, filler in the others (R1..R6)
        for (int i = 0; i < 15; i++) begin
            int k = i % 4;
            for (int l = 0; l < ML; l++) begin
                acc[l*32 +: 32] = 32'(32'h13579BDF * (i + 1) + l * 32'h0F0F1234);
                a[l*32 +: 16]    = 16'(i * 4099 + l * 257 + 17);
                a[l*32+16 +: 16] = 16'(i * 771 + l * 9001 + 3);
                b[l*32 +: 16]    = 16'(i * 6151 + l * 123 + 40000);
                b[l*32+16 +: 16] = 16'(i * 313 + l * 7777 + 5);
            end
            acc[k*32 +: 32]  = TBL[i].acc;
            a[k*32 +: 16]    = TBL[i].a0;
            a[k*32+16 +: 16] = TBL[i].a1;
            b[k*32 +: 16]    = TBL[i].b0;
            b[k*32+16 +: 16] = TBL[i].b1;
            expw = ref_vec(TBL[i].md, TBL[i].sat, acc, a, b, 8);
            expw[k*32 +: 32] = TBL[i].exp;
            expn = {128'b0, expw[127:0]};
            apply(TBL[i].md, TBL[i].sat, acc, a, b);
            check("R7 valid after input", {255'b0, out_valid}, 256'd1);
            check("R1-table wide lanes (R1 R2 R3 R4 R5)", out_data_w, expw);
            check("R6 four-lane output upper zero", out_data, expn);
        end

        // Corner sweep across every kind and both accumulation styles (R2 R3 R4 R5)
        for (int md = 0; md < 4; md++) begin
            for (int s = 0; s < 2; s++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int l = 0; l < ML; l++) begin
                        acc[l*32 +: 32]  = ca[(l + c) % 4];
                        a[l*32 +: 16]    = cw[(l + c) % 4];
                        a[l*32+16 +: 16] = cw[(l + 2*c + 1) % 4];
                        b[l*32 +: 16]    = cw[(3*l + c) % 4];
                        b[l*32+16 +: 16] = cw[(l + 3) % 4];
                    end
                    expw = ref_vec(2'(md), 1'(s), acc, a, b, 8);
                    apply(2'(md), 1'(s), acc, a, b);
                    check("R2 R3 R4 R5 corner wide", out_data_w, expw);
                    check("R6 corner four-lane", out_data, {128'b0, expw[127:0]});
                end
            end
        end

        // R8: idle cycle with new operands leaves the result unchanged
        held = out_data_w;
        in_valid = 1'b0; acc_in = ~acc_in; a_in = ~a_in; kind = 2'd0; sat_en = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 valid drops", {255'b0, out_valid_w}, 256'd0);
        check("R8 data held", out_data_w, held);

        // R6: changing only upper-half inputs has no effect on a four-lane build
        acc = {128'h0, 128'h00000001_00000002_00000003_00000004};
        a   = {128'h0, 128'h0003_0004_0005_0006_0007_0008_0009_000A};
        b   = {128'h0, 128'h0010_0020_0030_0040_0050_0060_0070_0080};
        apply(2'd2, 1'b0, acc, a, b);
        held = out_data;
        apply(2'd2, 1'b0, {~128'h0, acc[127:0]}, {~128'h0, a[127:0]}, {128'h1234, b[127:0]});
        check("R6 upper inputs ignored", out_data, held);

        // R9: reset while input is valid
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 mid reset valid", {255'b0, out_valid}, 256'd0);
        check("R9 mid reset data", out_data_w, 256'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end
endmodule